// File: doc/BRIEF.md
# Chained Cycle Counter

A 32-bit machine-cycle counter built from two linked 16-bit halves. It advances by one on every rising edge of the core clock that reaches it, and no clock divider or clock control setting changes that rate. Software sees the count as two 16-bit registers on a small register bus. The upper half sits at byte offset 0 and the lower half at byte offset 2. A read returns the count as it stands in that cycle. No half is latched. A write of any data to either offset clears the whole count.

The lower half keeps moving between two bus reads, so a 32-bit value is only safe when it is built from a read of the upper half, then the lower half, then the upper half again, and the two upper reads agree. The block includes a snapshot sequencer that runs this sequence for the caller. It reads one register per cycle and retries while the two upper reads disagree. It then presents the assembled 32-bit value together with a one-cycle done strobe.

The half width (`SEG_W`) and the carry structure (`CARRY_MODE`: chained segments, or one flat adder) are parameters. The total width is always two halves.

Top module: `chained_cycle_timer`

## Requirements
- R1: While `rst_n` is low, the count is zero, `snap_busy` and `snap_done` are low, and a bus read of either offset returns 0.
- R2: In each cycle without a clearing write, the count is one more than in the previous cycle, and a carry out of the lower half advances the upper half.
- R3: When `bus_en` and `bus_we` are both high at a clock edge, the count becomes 0 after that edge, whatever the data and the offset. The clear wins over the increment in that cycle, so the following cycles read 0, then 1.
- R4: With `bus_en` high, `bus_addr[1]` = 0 (offset 0) returns the upper half and `bus_addr[1]` = 1 (offset 2) returns the lower half. The value is the live count of the same cycle. With `bus_en` low, `bus_rdata` is 0.
- R5: After all ones, the count wraps to 0 and gives no other indication.
- R6: A `snap_start` seen while the sequencer is idle makes `snap_busy` high from the next cycle. `snap_busy` stays high until the cycle in which `snap_done` rises, and is low in that cycle.
- R7: When the two upper-half reads match, `snap_done` is high for exactly one cycle, four cycles after the start cycle. `snap_value` then equals the count in the cycle of the lower-half read, which is two cycles before `snap_done`, and it is held until the next done.
- R8: When the two upper-half reads differ, the second upper read becomes the new first read and the lower and upper reads are repeated, which adds two cycles. The delivered value still meets R7.
- R9: A `snap_start` seen while `snap_busy` is high is ignored: it neither restarts nor adds a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; the count advances on each rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write qualifier; a write clears the count |
| bus_addr | input | 2 | Byte offset; bit 1 picks the lower (1) or upper (0) half |
| bus_wdata | input | SEG_W | Write data, not used by the counter |
| bus_rdata | output | SEG_W | Live half selected by `bus_addr` |
| snap_start | input | 1 | Request a consistent snapshot |
| snap_busy | output | 1 | Snapshot sequence in progress |
| snap_done | output | 1 | One-cycle strobe: `snap_value` is updated |
| snap_value | output | 2*SEG_W | Consistent snapshot of the count |

## Verification
The value assertion compares the snapshot with the count two cycles before done. It is only valid when no clearing write occurred during the three cycles of reads before done, so it is disabled in that case. The bench never writes while a snapshot is in progress. The register-read assertions assume that `bus_addr` only has bit 1 meaningful. The bench drives only offsets 0 and 2. The sweeps use 4-bit halves, so that wraps of both halves and upper-half mismatches come up often within a short run.

// File: rtl/cct_pkg.sv
package cct_pkg;

   typedef enum logic [1:0] {
      SN_IDLE = 2'd0,
      SN_HI1  = 2'd1,
      SN_LO   = 2'd2,
      SN_HI2  = 2'd3
   } snap_state_e;

   localparam int unsigned OFFS_SEL_BIT = 1;   // bus_addr bit selecting the half
   localparam int unsigned BUS_ADDR_W   = 2;   // byte offsets 0 and 2

endpackage

// File: rtl/cct_seg.sv
module cct_seg #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         cin,
   output logic [W-1:0] q,
   output logic         cout
);

   always_ff @(posedge clk) begin
      if (!rst_n)      q <= '0;
      else if (clr)    q <= '0;
      else if (cin)    q <= q + W'(1);
   end

   assign cout = cin & (&q);

endmodule

// File: rtl/cct_regport.sv
module cct_regport
   import cct_pkg::*;
#(
   parameter int unsigned SEG_W = 16,
   localparam int unsigned CW   = 2 * SEG_W
) (
   input  logic                  bus_en,
   input  logic                  bus_we,
   input  logic [BUS_ADDR_W-1:0] bus_addr,
   input  logic [SEG_W-1:0]      bus_wdata,
   input  logic [CW-1:0]         cnt,
   output logic [SEG_W-1:0]      bus_rdata,
   output logic                  clr
);

   logic              pick_lo;
   logic [SEG_W-1:0]  sel_word;
   logic              unused_bits;

   // Any write, to any offset and with any data, clears the count.
   assign clr     = bus_en & bus_we;
   assign pick_lo = bus_addr[OFFS_SEL_BIT];

   always_comb begin
      if (pick_lo) sel_word = cnt[SEG_W-1:0];
      else         sel_word = cnt[CW-1:SEG_W];
   end

   assign bus_rdata   = bus_en ? sel_word : '0;
   assign unused_bits = ^{bus_wdata, bus_addr[0]};

endmodule

// File: rtl/cct_snap.sv
module cct_snap
   import cct_pkg::*;
#(
   parameter int unsigned SEG_W = 16,
   localparam int unsigned CW   = 2 * SEG_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [SEG_W-1:0] rd_word,
   output logic             rd_lo,
   output logic             busy,
   output logic             done,
   output logic [CW-1:0]    value
);

   snap_state_e      state_q;
   logic [SEG_W-1:0] hi1_q;
   logic [SEG_W-1:0] lo_q;
   logic             done_q;
   logic [CW-1:0]    val_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SN_IDLE;
         hi1_q   <= '0;
         lo_q    <= '0;
         done_q  <= 1'b0;
         val_q   <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            SN_IDLE: begin
               if (start) state_q <= SN_HI1;
            end
            SN_HI1: begin
               hi1_q   <= rd_word;
               state_q <= SN_LO;
            end
            SN_LO: begin
               lo_q    <= rd_word;
               state_q <= SN_HI2;
            end
            SN_HI2: begin
               if (rd_word == hi1_q) begin
                  val_q   <= {hi1_q, lo_q};
                  done_q  <= 1'b1;
                  state_q <= SN_IDLE;
               end else begin
                  // The fresh upper read opens a new high-low-high pass.
                  hi1_q   <= rd_word;
                  state_q <= SN_LO;
               end
            end
            default: state_q <= SN_IDLE;
         endcase
      end
   end

   assign rd_lo = (state_q == SN_LO);
   assign busy  = (state_q != SN_IDLE);
   assign done  = done_q;
   assign value = val_q;

endmodule

// File: rtl/chained_cycle_timer.sv
module chained_cycle_timer
   import cct_pkg::*;
#(
   parameter int unsigned SEG_W      = 16,
   parameter int unsigned CARRY_MODE = 1,
   localparam int unsigned CW        = 2 * SEG_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_en,
   input  logic                  bus_we,
   input  logic [BUS_ADDR_W-1:0] bus_addr,
   input  logic [SEG_W-1:0]      bus_wdata,
   output logic [SEG_W-1:0]      bus_rdata,
   input  logic                  snap_start,
   output logic                  snap_busy,
   output logic                  snap_done,
   output logic [CW-1:0]         snap_value
);

   if (SEG_W < 2 || SEG_W > 32) begin : g_bad_width
      $error("chained_cycle_timer: SEG_W must lie in 2..32");
   end
   if (CARRY_MODE > 1) begin : g_bad_mode
      $error("chained_cycle_timer: CARRY_MODE must be 0 or 1");
   end

   logic [CW-1:0]    cnt_q;
   logic             clr;
   logic             snap_rd_lo;
   logic [SEG_W-1:0] snap_word;

   cct_regport #(.SEG_W(SEG_W)) u_port (
      .bus_en    (bus_en),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .cnt       (cnt_q),
      .bus_rdata (bus_rdata),
      .clr       (clr)
   );

   if (CARRY_MODE == 1) begin : g_chain
      logic [1:0] carry;
      for (genvar s = 0; s < 2; s++) begin : g_seg
         logic seg_cin;
         logic seg_cout;
         if (s == 0) begin : g_first
            assign seg_cin = 1'b1;
         end else begin : g_next
            assign seg_cin = carry[s-1];
         end
         cct_seg #(.W(SEG_W)) u_seg (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (clr),
            .cin  (seg_cin),
            .q    (cnt_q[s*SEG_W +: SEG_W]),
            .cout (seg_cout)
         );
         assign carry[s] = seg_cout;
      end
      logic unused_carry;
      assign unused_carry = carry[1];
   end else begin : g_flat
      always_ff @(posedge clk) begin
         if (!rst_n)   cnt_q <= '0;
         else if (clr) cnt_q <= '0;
         else          cnt_q <= cnt_q + CW'(1);
      end
   end

   assign snap_word = snap_rd_lo ? cnt_q[SEG_W-1:0] : cnt_q[CW-1:SEG_W];

   cct_snap #(.SEG_W(SEG_W)) u_snap (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (snap_start),
      .rd_word(snap_word),
      .rd_lo  (snap_rd_lo),
      .busy   (snap_busy),
      .done   (snap_done),
      .value  (snap_value)
   );

endmodule

// File: rtl/cct_chk.sv
module cct_chk #(
   parameter int unsigned SEG_W = 16,
   localparam int unsigned CW   = 2 * SEG_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_en,
   input logic [1:0]       bus_addr,
   input logic [SEG_W-1:0] bus_rdata,
   input logic [CW-1:0]    cnt,
   input logic             clr,
   input logic             snap_start,
   input logic             snap_busy,
   input logic             snap_done,
   input logic [CW-1:0]    snap_value
);

   always @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_CLEAR: assert (!snap_done) else $error("done during reset"); // R1
      end
   end

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && cnt != {CW{1'b1}}) |=> cnt == $past(cnt) + CW'(1));            // R2

   AST_WRITE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> cnt == '0);                                                     // R3

   AST_READ_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && !bus_addr[1]) |-> bus_rdata == cnt[CW-1:SEG_W]);             // R4

   AST_READ_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && bus_addr[1]) |-> bus_rdata == cnt[SEG_W-1:0]);               // R4

   AST_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_en |-> bus_rdata == '0);                                           // R4

   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && cnt == {CW{1'b1}}) |=> cnt == '0);                             // R5

   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (snap_start && !snap_busy) |=> snap_busy);                              // R6

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      snap_done |-> !snap_busy);                                              // R6

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      snap_done |=> !snap_done);                                              // R7

   AST_VALUE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_done |-> $stable(snap_value));                                    // R7

   AST_SNAP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (snap_done && !$past(clr, 1) && !$past(clr, 2) && !$past(clr, 3))
         |-> snap_value == $past(cnt, 2));                                    // R8

endmodule

bind chained_cycle_timer cct_chk #(.SEG_W(SEG_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_en    (bus_en),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .cnt       (cnt_q),
   .clr       (clr),
   .snap_start(snap_start),
   .snap_busy (snap_busy),
   .snap_done (snap_done),
   .snap_value(snap_value)
);

// File: tb/sim_chained_cycle_timer.sv
module sim_chained_cycle_timer;

   localparam int unsigned SW = 4;
   localparam int unsigned CW = 2 * SW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_en = 1'b0;
   logic          bus_we = 1'b0;
   logic [1:0]    bus_addr = 2'd0;
   logic [SW-1:0] bus_wdata = '0;
   logic [SW-1:0] bus_rdata;
   logic          snap_start = 1'b0;
   logic          snap_busy;
   logic          snap_done;
   logic [CW-1:0] snap_value;

   int n_chk = 0;
   int n_err = 0;

   // Reference count from the requirements: +1 per cycle, 0 after a write.
   logic [CW-1:0] m_cnt = '0;
   logic [CW-1:0] m_h1  = '0;
   logic [CW-1:0] m_h2  = '0;

   always #10 clk = ~clk;

   chained_cycle_timer #(.SEG_W(SW), .CARRY_MODE(1)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .snap_start(snap_start), .snap_busy(snap_busy),
      .snap_done(snap_done), .snap_value(snap_value)
   );

   always @(posedge clk) begin
      if (!rst_n)                m_cnt <= '0;
      else if (bus_en && bus_we) m_cnt <= '0;
      else                       m_cnt <= m_cnt + CW'(1);
      m_h1 <= m_cnt;
      m_h2 <= m_h1;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic rd(input bit lo, output logic [SW-1:0] v);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = lo ? 2'd2 : 2'd0;
      #1 v = bus_rdata;
   endtask

   task automatic snapshot(input int req_busy_extra, output int lat);
      logic [CW-1:0] c1, c3;
      int k;
      c1 = m_cnt + CW'(1);
      c3 = m_cnt + CW'(3);
      snap_start = 1'b1;
      step();
      chk(snap_busy === 1'b1, "R6 busy after start", int'(snap_busy), 1);
      if (req_busy_extra == 0) snap_start = 1'b0;
      k = 1;
      while (!snap_done && k < 20) begin
         step();
         if (k == 1) snap_start = 1'b0;
         k++;
      end
      lat = k;
      chk(snap_value == m_h2, "R7 value", int'(snap_value), int'(m_h2));
      chk(snap_busy === 1'b0, "R6 idle at done", int'(snap_busy), 0);
      if (c1[CW-1:SW] == c3[CW-1:SW])
         chk(lat == 4, "R7 latency", lat, 4);
      else
         chk(lat == 6, "R8 retry latency", lat, 6);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk + 1, n_err);
      $finish;
   end

   initial begin
      logic [SW-1:0] v;
      int lat;
      int dones;

      // R1: reset state
      repeat (3) step();
      rd(1'b0, v);
      chk(v == '0, "R1 upper in reset", int'(v), 0);
      rd(1'b1, v);
      chk(v == '0, "R1 lower in reset", int'(v), 0);
      chk(snap_busy === 1'b0 && snap_done === 1'b0, "R1 snap idle", int'({snap_busy, snap_done}), 0);
      step();
      rst_n = 1'b1;

      // R2 R4 R5: read both halves every cycle through several wraps
      for (int i = 0; i < 700; i++) begin
         step();
         rd(i[0], v);
         if (i[0]) chk(v == m_cnt[SW-1:0], "R2 R4 lower half", int'(v), int'(m_cnt[SW-1:0]));
         else      chk(v == m_cnt[CW-1:SW], "R2 R4 upper half", int'(v), int'(m_cnt[CW-1:SW]));
         if (m_cnt == '0 && i > 2)
            chk(v == '0, "R5 wrap to zero", int'(v), 0);
      end
      step();
      bus_en = 1'b0; bus_addr = 2'd2;
      #1 chk(bus_rdata == '0, "R4 idle rdata", int'(bus_rdata), 0);

      // R3: writes of assorted data to both offsets, including at all ones
      for (int i = 0; i < 10; i++) begin
         for (int w = 0; w < 23 * i + 5; w++) step();
         if (i == 9) while (m_cnt != {CW{1'b1}}) step();
         bus_en = 1'b1; bus_we = 1'b1; bus_addr = i[0] ? 2'd2 : 2'd0;
         bus_wdata = SW'(i * 7 + 3);
         step();
         rd(1'b1, v);
         chk(v == '0, "R3 lower after clear", int'(v), 0);
         step();
         rd(1'b0, v);
         chk(v == '0, "R3 upper after clear", int'(v), 0);
         step();
         rd(1'b1, v);
         chk(v == SW'(2), "R3 count resumes", int'(v), 2);
         bus_en = 1'b0;
      end

      // R6 R7 R8: start a snapshot at every phase of the lower half
      for (int ph = 0; ph < 40; ph++) begin
         for (int w = 0; w <= ph % 17; w++) step();
         snapshot(0, lat);
      end

      // R9: start kept high while busy
      for (int ph = 0; ph < 8; ph++) begin
         for (int w = 0; w <= ph * 3; w++) step();
         while (m_cnt[SW-1:0] > SW'((1 << SW) - 6)) step();
         snapshot(1, lat);
         dones = 0;
         for (int w = 0; w < 12; w++) begin
            step();
            if (snap_done) dones++;
         end
         chk(dones == 0, "R9 no extra sequence", dones, 0);
      end

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule